// File: doc/BRIEF.md
# Pulse Accumulator with Timer Clock Selection

The block counts activity on one external input pin into a 16-bit accumulator. In event mode it adds one for each chosen edge of the pin. In gated mode a strobe that fires once every 64 bus clocks adds one to the count, but only while the pin stays at the chosen level. The edge that ends that level sets an input flag. A second flag records each wrap of the accumulator. Software can load the accumulator and clear either flag by writing a one to it.

The block also supplies a clock enable for a separate timer counter. A 2-bit select picks the source of this enable from four choices: the timer prescaler tick, each accumulator increment, one pulse per 256 increments, or one pulse per 65536 increments. The pin passes through two synchroniser flops before any edge or level is decoded.

Top module: `pulse_accum`

## Requirements
- R1: After reset, `count_o` is 0 and both `in_flag_o` and `ovf_flag_o` are 0.
- R2: With `acc_en_i`=1, `mode_i`=0 and `edge_sel_i`=1, `count_o` rises by exactly one for each rising edge on `pin_i`. Falling edges do not change it.
- R3: With `acc_en_i`=1, `mode_i`=0 and `edge_sel_i`=0, `count_o` rises by exactly one for each falling edge on `pin_i`.
- R4: With `mode_i`=1, `edge_sel_i`=0 and `timer_en_i`=1, the count rises once per 64-cycle strobe while the synchronised pin is high. A pin held high for 64·k cycles therefore adds exactly k. Only the falling edge that ends the high level sets `in_flag_o`.
- R5: With `mode_i`=1 and `edge_sel_i`=1, the same counting happens while the pin is low. The rising edge that ends the low level sets `in_flag_o`.
- R6: While `timer_en_i`=0 there is no 64-cycle strobe, so gated mode leaves `count_o` unchanged.
- R7: While `acc_en_i`=0, `mode_i` and `edge_sel_i` have no effect. Pin activity changes neither `count_o` nor `in_flag_o`.
- R8: An increment at 0xFFFF gives 0x0000 and sets `ovf_flag_o`.
- R9: `flag_clr_i` bit 0 clears `in_flag_o` and bit 1 clears `ovf_flag_o`. A set event in the same cycle as the clear leaves the flag set.
- R10: `cnt_wr_i`=1 loads `cnt_wdata_i` into the count on the next edge, and takes priority over an increment in the same cycle.
- R11: `clk_sel_i`=00 passes `presc_tick_i` to `tmr_clk_en_o` in the same cycle. `clk_sel_i`=01 gives one `tmr_clk_en_o` pulse per accumulator increment.
- R12: `clk_sel_i`=10 gives one single-cycle pulse per 256 accumulator increments. `clk_sel_i`=11 gives one per 65536.
- R13: In event mode, each counted edge also sets `in_flag_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timer_en_i | input | 1 | Timer enable; gates the 64-cycle strobe |
| acc_en_i | input | 1 | Accumulator enable |
| mode_i | input | 1 | 0 event counting, 1 gated time accumulation |
| edge_sel_i | input | 1 | Edge or level select; meaning depends on mode |
| clk_sel_i | input | 2 | Timer counter clock source select |
| presc_tick_i | input | 1 | Timer prescaler tick |
| pin_i | input | 1 | Asynchronous accumulator pin |
| cnt_wr_i | input | 1 | Count load strobe |
| cnt_wdata_i | input | 16 | Count load value |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 input flag, bit 1 overflow flag |
| count_o | output | 16 | Accumulator value |
| in_flag_o | output | 1 | Input edge flag |
| ovf_flag_o | output | 1 | Accumulator overflow flag |
| tmr_clk_en_o | output | 1 | Selected timer counter clock enable |

## Verification
A pin change reaches `count_o` and the flags on the third rising edge after it is driven: two synchroniser flops, then the counting register. The bench therefore waits at least four cycles after each pin change before it samples. A load or a flag clear shows up on the first edge after it is driven, so those results are sampled on the following falling edge. The select-00 path is combinational and is checked one nanosecond after the tick is driven. Gated counts use windows that are whole multiples of 64 cycles, so the expected count does not depend on the phase of the strobe. Timer enable pulses are counted over whole multiples of the division ratio, with a six-cycle tail, for the same reason.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  typedef enum logic [1:0] {
    CS_PRESC  = 2'b00,
    CS_ACC    = 2'b01,
    CS_DIV_LO = 2'b10,
    CS_DIV_HI = 2'b11
  } clk_src_e;

  typedef enum logic {
    MD_EVENT = 1'b0,
    MD_GATED = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/pacc_pin_sync.sv
module pacc_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_s_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign pin_s_o = sync_q[STAGES-1];
  assign rise_o  = pin_s_o & ~prev_q;
  assign fall_o  = ~pin_s_o & prev_q;
endmodule

// File: rtl/pacc_gate_tick.sv
module pacc_gate_tick #(
  parameter int unsigned DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned W = $clog2(DIV);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i)             cnt_q <= '0;
    else if (cnt_q == W'(DIV-1)) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == W'(DIV-1));
endmodule

// File: rtl/pacc_clk_div.sv
module pacc_clk_div #(
  parameter int unsigned LO_BITS = 8,
  parameter int unsigned HI_BITS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic lo_o,
  output logic hi_o
);
  logic [HI_BITS-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (evt_i) cnt_q <= cnt_q + 1'b1;
  end

  // pulse on the event that completes each period
  assign lo_o = evt_i && (&cnt_q[LO_BITS-1:0]);
  assign hi_o = evt_i && (&cnt_q);
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum
  import pacc_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned GATE_DIV  = 64,
  parameter int unsigned SYNC_N    = 2,
  parameter int unsigned DIV_LO_W  = 8,
  parameter int unsigned DIV_HI_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             timer_en_i,
  input  logic             acc_en_i,
  input  logic             mode_i,
  input  logic             edge_sel_i,
  input  logic [1:0]       clk_sel_i,
  input  logic             presc_tick_i,
  input  logic             pin_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic [1:0]       flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             in_flag_o,
  output logic             ovf_flag_o,
  output logic             tmr_clk_en_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic pin_s, pin_rise, pin_fall, gate_tick;
  logic sel_edge, acc_evt, in_set, ovf_set;
  logic div_lo, div_hi;
  logic [CNT_W-1:0] count_q;
  logic in_flag_q, ovf_flag_q;
  acc_mode_e mode;
  clk_src_e  csel;

  assign mode = acc_mode_e'(mode_i);
  assign csel = clk_src_e'(clk_sel_i);

  pacc_pin_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .pin_s_o(pin_s),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  pacc_gate_tick #(.DIV(GATE_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (timer_en_i),
    .tick_o(gate_tick)
  );

  // same edge polarity serves event counting and gated trailing edge
  assign sel_edge = edge_sel_i ? pin_rise : pin_fall;
  assign in_set   = acc_en_i && sel_edge;

  always_comb begin
    acc_evt = 1'b0;
    if (acc_en_i) begin
      unique case (mode)
        MD_EVENT: acc_evt = sel_edge;
        MD_GATED: acc_evt = gate_tick && (pin_s == ~edge_sel_i);
        default:  acc_evt = 1'b0;
      endcase
    end
  end

  assign ovf_set = acc_evt && !cnt_wr_i && (count_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       count_q <= '0;
    else if (cnt_wr_i) count_q <= cnt_wdata_i;
    else if (acc_evt)  count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_flag_q  <= 1'b0;
      ovf_flag_q <= 1'b0;
    end else begin
      in_flag_q  <= in_set  | (in_flag_q  & ~flag_clr_i[0]);
      ovf_flag_q <= ovf_set | (ovf_flag_q & ~flag_clr_i[1]);
    end
  end

  pacc_clk_div #(.LO_BITS(DIV_LO_W), .HI_BITS(DIV_HI_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (acc_evt),
    .lo_o  (div_lo),
    .hi_o  (div_hi)
  );

  always_comb begin
    unique case (csel)
      CS_PRESC:  tmr_clk_en_o = presc_tick_i;
      CS_ACC:    tmr_clk_en_o = acc_evt;
      CS_DIV_LO: tmr_clk_en_o = div_lo;
      CS_DIV_HI: tmr_clk_en_o = div_hi;
      default:   tmr_clk_en_o = 1'b0;
    endcase
  end

  assign count_o    = count_q;
  assign in_flag_o  = in_flag_q;
  assign ovf_flag_o = ovf_flag_q;
endmodule

// File: rtl/pulse_accum_chk.sv
module pulse_accum_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             timer_en_i,
  input logic             acc_en_i,
  input logic             mode_i,
  input logic [1:0]       clk_sel_i,
  input logic             cnt_wr_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic [1:0]       flag_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             in_flag_o,
  input logic             ovf_flag_o,
  input logic             tmr_clk_en_o,
  input logic             acc_evt,
  input logic             in_set
);
  assert_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> count_o == $past(cnt_wdata_i));

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_wr_i |=> (count_o == $past(count_o)) || (count_o == CNT_W'($past(count_o) + 1'b1)));

  assert_idle_cnt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_en_i && !cnt_wr_i) |=> count_o == $past(count_o));

  assert_idle_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_en_i && !in_flag_o) |=> !in_flag_o);

  assert_no_timer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && mode_i && !timer_en_i && !cnt_wr_i) |=> count_o == $past(count_o));

  assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_evt && !cnt_wr_i && (&count_o)) |=> (count_o == '0) && ovf_flag_o);

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_set && flag_clr_i[0]) |=> in_flag_o);

  assert_div_src_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_clk_en_o && clk_sel_i[1]) |-> acc_evt);
endmodule

bind pulse_accum pulse_accum_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .timer_en_i  (timer_en_i),
  .acc_en_i    (acc_en_i),
  .mode_i      (mode_i),
  .clk_sel_i   (clk_sel_i),
  .cnt_wr_i    (cnt_wr_i),
  .cnt_wdata_i (cnt_wdata_i),
  .flag_clr_i  (flag_clr_i),
  .count_o     (count_o),
  .in_flag_o   (in_flag_o),
  .ovf_flag_o  (ovf_flag_o),
  .tmr_clk_en_o(tmr_clk_en_o),
  .acc_evt     (acc_evt),
  .in_set      (in_set)
);

// File: tb/pulse_accum_tb_top.sv
`timescale 1ns/1ps
module pulse_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        timer_en = 1'b0, acc_en = 1'b0, mode = 1'b0, edge_sel = 1'b0;
  logic [1:0]  clk_sel = 2'b00;
  logic        presc_tick = 1'b0, pin = 1'b0, cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic [1:0]  flag_clr = '0;
  logic [15:0] count;
  logic        in_flag, ovf_flag, tmr_en;

  int n_chk = 0, n_fail = 0;
  int tmr_pulses = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pulse_accum dut_i (
    .clk_i(clk), .rst_ni(rst_n), .timer_en_i(timer_en), .acc_en_i(acc_en),
    .mode_i(mode), .edge_sel_i(edge_sel), .clk_sel_i(clk_sel),
    .presc_tick_i(presc_tick), .pin_i(pin), .cnt_wr_i(cnt_wr),
    .cnt_wdata_i(cnt_wdata), .flag_clr_i(flag_clr), .count_o(count),
    .in_flag_o(in_flag), .ovf_flag_o(ovf_flag), .tmr_clk_en_o(tmr_en)
  );

  always @(negedge clk) if (mon_on && tmr_en) tmr_pulses++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [15:0] v);
    cnt_wr = 1'b1; cnt_wdata = v; step(1);
    cnt_wr = 1'b0;
  endtask

  task automatic clr_flags();
    flag_clr = 2'b11; step(1);
    flag_clr = 2'b00;
  endtask

  task automatic pulses(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      pin = ~pin; step(half);
      pin = ~pin; step(half);
    end
  endtask

  task automatic t_reset();
    check(count == 0, "R1 count", count, 0);
    check(!in_flag && !ovf_flag, "R1 flags", {in_flag, ovf_flag}, 0);
  endtask

  task automatic t_event_rise();
    acc_en = 1'b1; mode = 1'b0; edge_sel = 1'b1; clk_sel = 2'b01;
    step(4); load(16'h0000); clr_flags();
    tmr_pulses = 0; mon_on = 1'b1;
    pulses(5, 4); step(6);
    mon_on = 1'b0;
    check(count == 5, "R2 rising count", count, 5);
    check(tmr_pulses == 5, "R11 acc clock pulses", tmr_pulses, 5);
    check(in_flag, "R13 edge sets flag", in_flag, 1);
    flag_clr = 2'b01; step(1); flag_clr = 2'b00;
    check(!in_flag, "R9 clear in flag", in_flag, 0);
  endtask

  task automatic t_event_fall();
    edge_sel = 1'b0; step(4);
    load(16'h0010);
    pulses(3, 4); step(6);
    check(count == 16'h13, "R3 falling count", count, 16'h13);
  endtask

  task automatic t_gated_high();
    timer_en = 1'b1; mode = 1'b1; edge_sel = 1'b0; pin = 1'b0;
    step(6); load(16'h0000); clr_flags();
    pin = 1'b1; step(64 * 3 - 10);
    check(!in_flag, "R4 no flag while high", in_flag, 0);
    step(10);
    pin = 1'b0; step(6);
    check(count == 3, "R4 gated high count", count, 3);
    check(in_flag, "R4 trailing fall flag", in_flag, 1);
  endtask

  task automatic t_gated_low();
    pin = 1'b1; step(6);
    edge_sel = 1'b1; step(2);
    load(16'h0000); clr_flags();
    pin = 1'b0; step(128);
    pin = 1'b1; step(6);
    check(count == 2, "R5 gated low count", count, 2);
    check(in_flag, "R5 trailing rise flag", in_flag, 1);
  endtask

  task automatic t_no_timer();
    timer_en = 1'b0; edge_sel = 1'b0; pin = 1'b0; step(6);
    load(16'h0040);
    pin = 1'b1; step(200);
    pin = 1'b0; step(6);
    check(count == 16'h40, "R6 no timer no count", count, 16'h40);
    timer_en = 1'b1;
  endtask

  task automatic t_disabled();
    acc_en = 1'b0; mode = 1'b0; edge_sel = 1'b1; step(4);
    load(16'h0007); clr_flags();
    pulses(4, 4); step(6);
    check(count == 7, "R7 disabled count", count, 7);
    check(!in_flag, "R7 disabled flag", in_flag, 0);
    acc_en = 1'b1;
  endtask

  task automatic t_wrap();
    load(16'hFFFE); clr_flags();
    pulses(1, 4); step(6);
    check(count == 16'hFFFF && !ovf_flag, "R8 before wrap", {ovf_flag, count}, 16'hFFFF);
    pulses(1, 4); step(6);
    check(count == 0, "R8 wrap count", count, 0);
    check(ovf_flag, "R8 overflow flag", ovf_flag, 1);
    flag_clr = 2'b10; step(1); flag_clr = 2'b00;
    check(!ovf_flag, "R9 clear overflow", ovf_flag, 0);
  endtask

  task automatic t_load_prio();
    mode = 1'b1; edge_sel = 1'b0; timer_en = 1'b1;
    pin = 1'b1; step(4);
    cnt_wr = 1'b1; cnt_wdata = 16'h1234;
    step(70);
    check(count == 16'h1234, "R10 load over tick", count, 16'h1234);
    cnt_wr = 1'b0;
    pin = 1'b0; step(6);
    mode = 1'b0; edge_sel = 1'b1;
  endtask

  task automatic t_sel_presc();
    clk_sel = 2'b00;
    presc_tick = 1'b1; #1;
    check(tmr_en, "R11 presc tick high", tmr_en, 1);
    step(1);
    presc_tick = 1'b0; #1;
    check(!tmr_en, "R11 presc tick low", tmr_en, 0);
  endtask

  task automatic t_div256();
    clk_sel = 2'b10; step(2);
    tmr_pulses = 0; mon_on = 1'b1;
    pulses(512, 2); step(6);
    mon_on = 1'b0;
    check(tmr_pulses == 2, "R12 div 256", tmr_pulses, 2);
  endtask

  task automatic t_div65536();
    clk_sel = 2'b11; step(2);
    tmr_pulses = 0; mon_on = 1'b1;
    pulses(65536, 1); step(6);
    mon_on = 1'b0;
    check(tmr_pulses == 1, "R12 div 65536", tmr_pulses, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_event_rise();
    t_event_fall();
    t_gated_high();
    t_gated_low();
    t_no_timer();
    t_disabled();
    t_wrap();
    t_load_prio();
    t_sel_presc();
    t_div256();
    t_div65536();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (195000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule